// File: doc/BRIEF.md
# DDR Command Timing Rule Checker

This block is a passive observer placed beside a DDR SDRAM controller. On every controller clock it samples the command bus: chip select, the three strobes, the bank address and the auto-precharge address bit. From these it works out which command was issued. It keeps a row-open flag and a set of down-counters for each bank, plus shared counters for rules that span all banks. When a command arrives too early, or in a bank state where it is not allowed, the block raises a violation flag. The flag stays high until it is cleared, and it comes with a one-hot code that names the first rule that was broken.

Every timing limit is a parameter given in picoseconds, or in clocks for the rules that are clock-based. The block converts each one to a whole number of cycles for the configured clock period. The defaults describe a 6 ns clock. The checker never drives the bus. It only reports.

Top module: `ddr_timing_monitor`

## Requirements
- R1: A command is decoded only while cs_n is 0. Reading {ras_n,cas_n,we_n}, 011 is ACTIVATE, 101 is READ, 100 is WRITE, 010 is PRECHARGE, 001 is REFRESH and 000 is MODE SET. With cs_n at 1, or any other strobe pattern, nothing is decoded and no state changes.
- R2: Code bit 0 (bank state) is raised by any of these: a READ or WRITE to a bank with no open row, an ACTIVATE to a bank whose row is already open, or a REFRESH or MODE SET while any row is open.
- R3: Code bit 1 is raised by a READ or WRITE to an open bank fewer than 3 cycles after that bank's ACTIVATE.
- R4: Code bit 2 is raised by an ACTIVATE to an idle bank before that bank is ready, measured from when it closed. After PRECHARGE the minimum gap is 3 cycles. After READ with auto-precharge it is 5 cycles (burst 2 + precharge 3). After WRITE with auto-precharge it is 9 cycles (burst 2 + 1 + write recovery 3 + precharge 3).
- R5: Code bit 3 is raised by a PRECHARGE that closes a row fewer than 7 cycles after its ACTIVATE. PRECHARGE with ap=1 acts on every bank. Code bit 4 is raised once a row has been open for more than 11667 cycles.
- R6: Code bit 5 is raised by an ACTIVATE fewer than 10 cycles after the previous ACTIVATE to the same bank.
- R7: Code bit 6 is raised by an ACTIVATE fewer than 2 cycles after any earlier ACTIVATE.
- R8: Code bit 7 is raised by a PRECHARGE that closes a bank fewer than 6 cycles after a WRITE to that bank.
- R9: Code bit 8 is raised by a READ fewer than 4 cycles after any WRITE.
- R10: Code bit 9 is raised by a READ or WRITE fewer than 2 cycles after the previous READ or WRITE. The minimum gap is the larger of the column spacing and the burst length in clocks.
- R11: Code bit 10 is raised by any command fewer than 2 cycles after MODE SET. Code bit 11 is raised by any command fewer than 12 cycles after REFRESH.
- R12: viol and viol_code update at the clock edge that samples the offending command. If several rules break at once, the lowest code bit wins. Once set, the flag and code hold until clr is 1, which zeroes both on the next edge.
- R13: Each nanosecond limit becomes ceil(limit / clock period) cycles. The defaults are 6 ns clock, 18 ns activate-to-column, 18 ns precharge, 42 ns minimum and 70 µs maximum row-open time, 60 ns row cycle, 12 ns activate spacing, 15 ns write recovery, 72 ns refresh, 12 ns mode set and burst length 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset of all tracking state |
| clr | input | 1 | Synchronous clear of the violation flag and code |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap | input | 1 | Auto-precharge / all-banks address bit |
| viol | output | 1 | Sticky violation flag |
| viol_code | output | NRULE | One-hot code of the first broken rule |

## Verification
Each rule is driven twice. First it is broken by exactly one cycle, and the bench checks that only its code bit appears. Then the same sequence is replayed with one more cycle of spacing, and the bench checks that no violation is flagged. This pins down the boundary of every derived limit.

Auto-precharge reads and writes are used to separate the row-cycle rule from the precharge rule. A sequence that breaks two rules at once shows the priority order. A deselected activate pattern shows that cs_n gates decoding. A long idle row shows the maximum-open limit. A precharge-all with two rows open shows that per-bank checks are applied to every bank it closes.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

  typedef enum logic [2:0] {
    C_NONE = 3'd0,
    C_ACT  = 3'd1,
    C_RD   = 3'd2,
    C_WR   = 3'd3,
    C_PRE  = 3'd4,
    C_REF  = 3'd5,
    C_MRS  = 3'd6
  } cmd_e;

  // Rule bit positions; lower index has priority.
  localparam int RI_STATE  = 0;
  localparam int RI_RCD    = 1;
  localparam int RI_RP     = 2;
  localparam int RI_RAS    = 3;
  localparam int RI_RASMAX = 4;
  localparam int RI_RC     = 5;
  localparam int RI_RRD    = 6;
  localparam int RI_WR     = 7;
  localparam int RI_WTR    = 8;
  localparam int RI_COL    = 9;
  localparam int RI_MRD    = 10;
  localparam int RI_RFC    = 11;
  localparam int NRULE     = 12;

  // Round a time in picoseconds up to whole clocks.
  function automatic int ps2cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NONE;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_mon_pkg::*;
#(
  parameter int TW        = 14,
  parameter int RCD_CK    = 3,
  parameter int RP_CK     = 3,
  parameter int RAS_CK    = 7,
  parameter int RASMAX_CK = 11667,
  parameter int RC_CK     = 10,
  parameter int WR_CK     = 3,
  parameter int BURST_CK  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  cmd_e cmd,
  input  logic ap,
  output logic open_o,
  output logic v_state,
  output logic v_rcd,
  output logic v_rp,
  output logic v_ras,
  output logic v_rasmax,
  output logic v_rc,
  output logic v_wr
);
  // Each counter is loaded with (minimum gap - 1) and counts down to zero.
  localparam logic [TW-1:0] L_RCD    = TW'(RCD_CK - 1);
  localparam logic [TW-1:0] L_RAS    = TW'(RAS_CK - 1);
  localparam logic [TW-1:0] L_RC     = TW'(RC_CK - 1);
  localparam logic [TW-1:0] L_RP     = TW'(RP_CK - 1);
  localparam logic [TW-1:0] L_WRREC  = TW'(BURST_CK + WR_CK);
  localparam logic [TW-1:0] L_RDAP   = TW'(BURST_CK + RP_CK - 1);
  localparam logic [TW-1:0] L_WRAP   = TW'(BURST_CK + WR_CK + RP_CK);
  localparam logic [TW-1:0] AGE_TOP  = TW'(RASMAX_CK + 1);

  logic          is_open;
  logic [TW-1:0] rcd_cnt, ras_cnt, rc_cnt, rp_cnt, wr_cnt, age;
  logic          hit_act, hit_col, hit_pre, glob_cmd;

  assign hit_act  = (cmd == C_ACT) && sel;
  assign hit_col  = ((cmd == C_RD) || (cmd == C_WR)) && sel;
  assign hit_pre  = (cmd == C_PRE) && (sel || ap);
  assign glob_cmd = (cmd == C_REF) || (cmd == C_MRS);

  assign open_o   = is_open;
  assign v_state  = (hit_act && is_open) || (hit_col && !is_open) || (glob_cmd && is_open);
  assign v_rcd    = hit_col && is_open && (rcd_cnt != '0);
  assign v_rp     = hit_act && !is_open && (rp_cnt != '0);
  assign v_rc     = hit_act && (rc_cnt != '0);
  assign v_ras    = hit_pre && is_open && (ras_cnt != '0);
  assign v_wr     = hit_pre && is_open && (wr_cnt != '0);
  assign v_rasmax = is_open && (age == AGE_TOP);

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] v);
    return (v != '0) ? v - 1'b1 : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      rcd_cnt <= '0;
      ras_cnt <= '0;
      rc_cnt  <= '0;
      rp_cnt  <= '0;
      wr_cnt  <= '0;
      age     <= '0;
    end else begin
      rcd_cnt <= dec(rcd_cnt);
      ras_cnt <= dec(ras_cnt);
      rc_cnt  <= dec(rc_cnt);
      rp_cnt  <= dec(rp_cnt);
      wr_cnt  <= dec(wr_cnt);
      if (is_open && age != AGE_TOP) age <= age + 1'b1;

      if (hit_act && !is_open) begin
        is_open <= 1'b1;
        rcd_cnt <= L_RCD;
        ras_cnt <= L_RAS;
        rc_cnt  <= L_RC;
        age     <= TW'(1);
      end else if (hit_col && is_open) begin
        if (cmd == C_WR) wr_cnt <= L_WRREC;
        if (ap) begin
          is_open <= 1'b0;
          age     <= '0;
          rp_cnt  <= (cmd == C_WR) ? L_WRAP : L_RDAP;
        end
      end else if (hit_pre && is_open) begin
        is_open <= 1'b0;
        age     <= '0;
        rp_cnt  <= L_RP;
      end
    end
  end
endmodule

// File: rtl/ddr_global_track.sv
module ddr_global_track
  import ddr_mon_pkg::*;
#(
  parameter int TW       = 14,
  parameter int RRD_CK   = 2,
  parameter int WTR_CK   = 1,
  parameter int COLGAP   = 2,
  parameter int MRD_CK   = 2,
  parameter int RFC_CK   = 12,
  parameter int BURST_CK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd,
  output logic v_rrd,
  output logic v_wtr,
  output logic v_col,
  output logic v_mrd,
  output logic v_rfc
);
  localparam logic [TW-1:0] L_RRD = TW'(RRD_CK - 1);
  localparam logic [TW-1:0] L_WTR = TW'(BURST_CK + WTR_CK);
  localparam logic [TW-1:0] L_COL = TW'(COLGAP - 1);
  localparam logic [TW-1:0] L_MRD = TW'(MRD_CK - 1);
  localparam logic [TW-1:0] L_RFC = TW'(RFC_CK - 1);

  logic [TW-1:0] rrd_cnt, wtr_cnt, col_cnt, mrd_cnt, rfc_cnt;
  logic          any_cmd, is_col;

  assign any_cmd = (cmd != C_NONE);
  assign is_col  = (cmd == C_RD) || (cmd == C_WR);

  assign v_rrd = (cmd == C_ACT) && (rrd_cnt != '0);
  assign v_wtr = (cmd == C_RD) && (wtr_cnt != '0);
  assign v_col = is_col && (col_cnt != '0);
  assign v_mrd = any_cmd && (mrd_cnt != '0);
  assign v_rfc = any_cmd && (rfc_cnt != '0);

  function automatic logic [TW-1:0] dec(input logic [TW-1:0] v);
    return (v != '0) ? v - 1'b1 : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt <= '0;
      wtr_cnt <= '0;
      col_cnt <= '0;
      mrd_cnt <= '0;
      rfc_cnt <= '0;
    end else begin
      rrd_cnt <= (cmd == C_ACT) ? L_RRD : dec(rrd_cnt);
      wtr_cnt <= (cmd == C_WR)  ? L_WTR : dec(wtr_cnt);
      col_cnt <= is_col         ? L_COL : dec(col_cnt);
      mrd_cnt <= (cmd == C_MRS) ? L_MRD : dec(mrd_cnt);
      rfc_cnt <= (cmd == C_REF) ? L_RFC : dec(rfc_cnt);
    end
  end
endmodule

// File: rtl/ddr_viol_latch.sv
module ddr_viol_latch #(
  parameter int NR = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NR-1:0] hits,
  output logic          viol,
  output logic [NR-1:0] code
);
  logic [NR-1:0] first;
  assign first = hits & (~hits + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      viol <= 1'b0;
      code <= '0;
    end else if (!viol && (hits != '0)) begin
      viol <= 1'b1;
      code <= first;
    end
  end
endmodule

// File: rtl/ddr_timing_monitor.sv
module ddr_timing_monitor
  import ddr_mon_pkg::*;
#(
  parameter int CLK_PS      = 6000,
  parameter int T_RCD_PS    = 18000,
  parameter int T_RP_PS     = 18000,
  parameter int T_RAS_PS    = 42000,
  parameter int T_RASMAX_PS = 70000000,
  parameter int T_RC_PS     = 60000,
  parameter int T_RRD_PS    = 12000,
  parameter int T_WR_PS     = 15000,
  parameter int T_RFC_PS    = 72000,
  parameter int T_MRD_PS    = 12000,
  parameter int T_WTR_CK    = 1,
  parameter int T_CCD_CK    = 1,
  parameter int BURST_LEN   = 4,
  parameter int NBANK       = 4,
  localparam int BA_W       = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             ap,
  output logic             viol,
  output logic [NRULE-1:0] viol_code
);
  localparam int RCD_CK    = ps2cyc(T_RCD_PS, CLK_PS);
  localparam int RP_CK     = ps2cyc(T_RP_PS, CLK_PS);
  localparam int RAS_CK    = ps2cyc(T_RAS_PS, CLK_PS);
  localparam int RASMAX_CK = ps2cyc(T_RASMAX_PS, CLK_PS);
  localparam int RC_CK     = ps2cyc(T_RC_PS, CLK_PS);
  localparam int RRD_CK    = ps2cyc(T_RRD_PS, CLK_PS);
  localparam int WR_CK     = ps2cyc(T_WR_PS, CLK_PS);
  localparam int RFC_CK    = ps2cyc(T_RFC_PS, CLK_PS);
  localparam int MRD_CK    = ps2cyc(T_MRD_PS, CLK_PS);
  localparam int BURST_CK  = BURST_LEN / 2;
  localparam int COLGAP    = max2(T_CCD_CK, BURST_CK);
  localparam int TW        = $clog2(RASMAX_CK + 2);

  cmd_e cmd;
  logic ev_act, ev_rd, ev_wr, ev_pre, ev_ref, ev_mrs;

  ddr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign ev_act = (cmd == C_ACT);
  assign ev_rd  = (cmd == C_RD);
  assign ev_wr  = (cmd == C_WR);
  assign ev_pre = (cmd == C_PRE);
  assign ev_ref = (cmd == C_REF);
  assign ev_mrs = (cmd == C_MRS);

  logic [NBANK-1:0] bank_open, b_state, b_rcd, b_rp, b_ras, b_rasmax, b_rc, b_wr;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr_bank_track #(
      .TW(TW), .RCD_CK(RCD_CK), .RP_CK(RP_CK), .RAS_CK(RAS_CK),
      .RASMAX_CK(RASMAX_CK), .RC_CK(RC_CK), .WR_CK(WR_CK), .BURST_CK(BURST_CK)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .sel(ba == BA_W'(b)), .cmd(cmd), .ap(ap),
      .open_o(bank_open[b]), .v_state(b_state[b]), .v_rcd(b_rcd[b]),
      .v_rp(b_rp[b]), .v_ras(b_ras[b]), .v_rasmax(b_rasmax[b]),
      .v_rc(b_rc[b]), .v_wr(b_wr[b])
    );
  end

  logic g_rrd, g_wtr, g_col, g_mrd, g_rfc;

  ddr_global_track #(
    .TW(TW), .RRD_CK(RRD_CK), .WTR_CK(T_WTR_CK), .COLGAP(COLGAP),
    .MRD_CK(MRD_CK), .RFC_CK(RFC_CK), .BURST_CK(BURST_CK)
  ) u_glob (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .v_rrd(g_rrd), .v_wtr(g_wtr), .v_col(g_col), .v_mrd(g_mrd), .v_rfc(g_rfc)
  );

  logic [NRULE-1:0] rule_hits;
  always_comb begin
    rule_hits            = '0;
    rule_hits[RI_STATE]  = |b_state;
    rule_hits[RI_RCD]    = |b_rcd;
    rule_hits[RI_RP]     = |b_rp;
    rule_hits[RI_RAS]    = |b_ras;
    rule_hits[RI_RASMAX] = |b_rasmax;
    rule_hits[RI_RC]     = |b_rc;
    rule_hits[RI_RRD]    = g_rrd;
    rule_hits[RI_WR]     = |b_wr;
    rule_hits[RI_WTR]    = g_wtr;
    rule_hits[RI_COL]    = g_col;
    rule_hits[RI_MRD]    = g_mrd;
    rule_hits[RI_RFC]    = g_rfc;
  end

  ddr_viol_latch #(.NR(NRULE)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hits(rule_hits),
    .viol(viol), .code(viol_code)
  );
endmodule

// File: rtl/ddr_timing_monitor_sva.sv
module ddr_timing_monitor_sva #(
  parameter int NB   = 4,
  parameter int BA_W = 2,
  parameter int NR   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr,
  input logic            cs_n,
  input logic [BA_W-1:0] ba,
  input logic            viol,
  input logic [NR-1:0]   viol_code,
  input logic            ev_act,
  input logic            ev_rd,
  input logic            ev_wr,
  input logic            ev_pre,
  input logic            ev_ref,
  input logic            ev_mrs,
  input logic [NB-1:0]   bank_open
);
  p_decode_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_act, ev_rd, ev_wr, ev_pre, ev_ref, ev_mrs}));

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(ev_act || ev_rd || ev_wr || ev_pre || ev_ref || ev_mrs));

  for (genvar b = 0; b < NB; b++) begin : g_b
    p_open_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_act && ba == BA_W'(b) && !bank_open[b]) |=> bank_open[b]);
    p_close_needs_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_open[b] && !ev_pre && !ev_rd && !ev_wr) |=> bank_open[b]);
  end

  p_rcd_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(viol) && viol_code[1]) |-> $past(ev_rd || ev_wr));

  p_rrd_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(viol) && viol_code[6]) |-> $past(ev_act));

  p_code_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $onehot(viol_code));

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clr) |=> (viol && $stable(viol_code)));

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!viol && viol_code == '0));
endmodule

bind ddr_timing_monitor ddr_timing_monitor_sva #(.NB(NBANK), .BA_W(BA_W), .NR(ddr_mon_pkg::NRULE)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .ba(ba),
  .viol(viol), .viol_code(viol_code),
  .ev_act(ev_act), .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_pre(ev_pre),
  .ev_ref(ev_ref), .ev_mrs(ev_mrs), .bank_open(bank_open)
);

// File: tb/ddr_timing_monitor_bench.sv
module ddr_timing_monitor_bench;
  localparam int NR = 12;
  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000,
                         K_NOP = 3'b111;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  localparam int RASMAX = ceil_div(70000000, 6000);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap = 1'b0;
  logic [1:0] ba = 2'd0;
  logic viol;
  logic [NR-1:0] viol_code;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddr_timing_monitor u_ddr_timing_monitor (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap(ap), .viol(viol), .viol_code(viol_code)
  );

  function automatic logic [NR-1:0] bitc(input int i);
    return NR'(1) << i;
  endfunction

  task automatic issue(input logic [2:0] k, input int b, input logic a);
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = k; ba = 2'(b); ap = a;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(K_NOP, 0, 1'b0);
  endtask

  task automatic chk(input string req, input logic ev, input logic [NR-1:0] ec);
    issue(K_NOP, 0, 1'b0);
    n_tests++;
    if (viol !== ev || viol_code !== ec) begin
      n_fail++;
      $display("FAIL %s: viol=%0b code=%03h expected viol=%0b code=%03h",
               req, viol, viol_code, ev, ec);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cs_n = 1'b1; clr = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 reset state", 1'b0, '0);
  endtask

  task automatic t_legal();  // R1 R3 R5 R6 legal spacing; deselect ignored
    do_reset();
    issue(K_ACT, 0, 0); nops(2); issue(K_RD, 0, 0); nops(3);
    issue(K_PRE, 0, 0); nops(2); issue(K_ACT, 0, 0);
    chk("R13 legal sequence", 1'b0, '0);
    @(negedge clk); cs_n = 1'b1; {ras_n, cas_n, we_n} = K_ACT; ba = 2'd0;
    chk("R1 deselected activate ignored", 1'b0, '0);
  endtask

  task automatic t_state();
    do_reset(); issue(K_RD, 2, 0);
    chk("R2 read to idle bank", 1'b1, bitc(0));
    do_reset(); issue(K_ACT, 1, 0); nops(20); issue(K_REF, 0, 0);
    chk("R2 refresh with open row", 1'b1, bitc(0));
  endtask

  task automatic t_rcd();
    do_reset(); issue(K_ACT, 0, 0); nops(1); issue(K_RD, 0, 0);
    chk("R3 activate to read gap 2", 1'b1, bitc(1));
  endtask

  task automatic t_rrd();
    do_reset(); issue(K_ACT, 0, 0); issue(K_ACT, 1, 0);
    chk("R7 activate spacing 1", 1'b1, bitc(6));
    do_reset(); issue(K_ACT, 0, 0); nops(1); issue(K_ACT, 1, 0);
    chk("R7 activate spacing 2 legal", 1'b0, '0);
  endtask

  task automatic t_ras();
    do_reset(); issue(K_ACT, 3, 0); nops(5); issue(K_PRE, 3, 0);
    chk("R5 precharge at 6", 1'b1, bitc(3));
    do_reset(); issue(K_ACT, 3, 0); nops(6); issue(K_PRE, 3, 0);
    chk("R5 precharge at 7 legal", 1'b0, '0);
  endtask

  task automatic t_prio();  // R12 priority, R4 precharge time
    do_reset(); issue(K_ACT, 0, 0); nops(6); issue(K_PRE, 0, 0);
    nops(1); issue(K_ACT, 0, 0);
    chk("R4 R12 precharge and row cycle both broken", 1'b1, bitc(2));
  endtask

  task automatic t_rc();
    do_reset(); issue(K_ACT, 0, 0); nops(2); issue(K_RD, 0, 1);
    nops(4); issue(K_ACT, 0, 0);
    chk("R6 row cycle after read auto-precharge", 1'b1, bitc(5));
  endtask

  task automatic t_wr();
    do_reset(); issue(K_ACT, 1, 0); nops(2); issue(K_WR, 1, 0);
    nops(4); issue(K_PRE, 1, 0);
    chk("R8 write recovery gap 5", 1'b1, bitc(7));
    do_reset(); issue(K_ACT, 1, 0); nops(2); issue(K_WR, 1, 0);
    nops(5); issue(K_PRE, 1, 0);
    chk("R8 write recovery gap 6 legal", 1'b0, '0);
  endtask

  task automatic t_wtr();
    do_reset(); issue(K_ACT, 0, 0); nops(1); issue(K_ACT, 1, 0);
    issue(K_WR, 0, 0); nops(2); issue(K_RD, 1, 0);
    chk("R9 write to read gap 3", 1'b1, bitc(8));
    do_reset(); issue(K_ACT, 0, 0); nops(1); issue(K_ACT, 1, 0);
    issue(K_WR, 0, 0); nops(3); issue(K_RD, 1, 0);
    chk("R9 write to read gap 4 legal", 1'b0, '0);
  endtask

  task automatic t_col();
    do_reset(); issue(K_ACT, 0, 0); nops(2); issue(K_RD, 0, 0); issue(K_RD, 0, 0);
    chk("R10 column gap 1", 1'b1, bitc(9));
    do_reset(); issue(K_ACT, 0, 0); nops(2); issue(K_RD, 0, 0); nops(1); issue(K_RD, 0, 0);
    chk("R10 column gap 2 legal", 1'b0, '0);
  endtask

  task automatic t_mrd_rfc();
    do_reset(); issue(K_MRS, 0, 0); issue(K_ACT, 0, 0);
    chk("R11 mode set gap 1", 1'b1, bitc(10));
    do_reset(); issue(K_MRS, 0, 0); nops(1); issue(K_ACT, 0, 0);
    chk("R11 mode set gap 2 legal", 1'b0, '0);
    do_reset(); issue(K_REF, 0, 0); nops(3); issue(K_ACT, 0, 0);
    chk("R11 refresh gap 4", 1'b1, bitc(11));
    do_reset(); issue(K_REF, 0, 0); nops(11); issue(K_ACT, 0, 0);
    chk("R11 refresh gap 12 legal", 1'b0, '0);
  endtask

  task automatic t_wap();
    do_reset(); issue(K_ACT, 2, 0); nops(2); issue(K_WR, 2, 1);
    nops(7); issue(K_ACT, 2, 0);
    chk("R4 write auto-precharge gap 8", 1'b1, bitc(2));
    do_reset(); issue(K_ACT, 2, 0); nops(2); issue(K_WR, 2, 1);
    nops(8); issue(K_ACT, 2, 0);
    chk("R4 write auto-precharge gap 9 legal", 1'b0, '0);
  endtask

  task automatic t_sticky();
    do_reset(); issue(K_ACT, 0, 0); issue(K_RD, 0, 0);
    nops(3); issue(K_RD, 0, 0); issue(K_RD, 0, 0);
    chk("R12 first code held", 1'b1, bitc(1));
    @(negedge clk); clr = 1'b1; {ras_n, cas_n, we_n} = K_NOP;
    @(negedge clk); clr = 1'b0;
    chk("R12 clear", 1'b0, '0);
  endtask

  task automatic t_preall();
    do_reset(); issue(K_ACT, 0, 0); nops(1); issue(K_ACT, 1, 0);
    nops(5); issue(K_PRE, 0, 1);
    chk("R5 precharge all with young row", 1'b1, bitc(3));
    do_reset(); issue(K_ACT, 0, 0); nops(1); issue(K_ACT, 1, 0);
    nops(6); issue(K_PRE, 0, 1); nops(2); issue(K_ACT, 0, 0);
    nops(1); issue(K_ACT, 1, 0);
    chk("R2 precharge all closes both banks", 1'b0, '0);
  endtask

  task automatic t_rasmax();
    do_reset(); issue(K_ACT, 0, 0); nops(RASMAX);
    chk("R5 row open at limit", 1'b0, '0);
    chk("R5 row open beyond limit", 1'b1, bitc(4));
  endtask

  initial begin
    t_reset(); t_legal(); t_state(); t_rcd(); t_rrd(); t_ras(); t_prio();
    t_rc(); t_wr(); t_wtr(); t_col(); t_mrd_rfc(); t_wap(); t_sticky();
    t_preall(); t_rasmax();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule